// File: doc/BRIEF.md
# Keyed Byte Substitution and MDS Mixing Unit

This unit evaluates the keyed g-function of a 128-bit Feistel block cipher with 32-bit words. It holds four substitution tables of 256 bytes each, one for each byte position of a 32-bit word. A key-setup engine elsewhere fills the tables through a byte-wide write port. Once the tables are loaded, each input byte looks up its own table. The four substituted bytes then go through a fixed 4x4 maximum-distance-separable matrix over GF(2^8), which produces a 32-bit result.

Two read lanes share the tables, so both g evaluations of one cipher round finish in the same cycle. The reads are combinational from the registered table contents. Table contents stay in place from block to block. A new key means reloading all four tables. Writes arriving while the surrounding datapath reports busy are dropped, so a block in flight always sees one consistent set of tables.

Top module: `gfun_mixer`

## Requirements
- R1: A synchronous reset (rst_n low at a rising clock edge) clears every entry of all four tables to 0x00. After that edge both lane outputs read 0x00000000 for any input.
- R2: When ld_we_i is high and busy_i is low at a rising edge, ld_data_i is stored in table ld_sel_i (values 0 to 3) at entry ld_addr_i. Reads see the new value from that edge onward.
- R3: When busy_i is high, a write request has no effect. The addressed entry keeps its old value, as the lane outputs show.
- R4: Input byte k (bits 8k+7 down to 8k, byte 0 least significant) indexes table k, and only table k.
- R5: The substituted bytes y0..y3 are mixed over GF(2^8) with reduction polynomial x^8+x^6+x^5+x^3+1 (0x169). Output byte i = XOR over j of M[i][j]*y_j. The rows are M0={01,EF,5B,5B}, M1={5B,EF,EF,01}, M2={EF,5B,01,EF} and M3={EF,01,EF,5B}, and output byte 0 is bits 7:0.
- R6: Lanes A and B use the same tables and evaluate independently in the same cycle. Equal lane inputs give equal lane outputs.
- R7: The lane outputs are combinational. A change on a lane input shows on its output with no clock edge.
- R8: Table contents persist with no writes, whatever the lane activity, until they are rewritten or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset, clears the tables |
| busy_i | input | 1 | High while a block is in flight; blocks table writes |
| ld_we_i | input | 1 | Table write request |
| ld_sel_i | input | 2 | Table number 0..3 for the write |
| ld_addr_i | input | 8 | Entry address for the write |
| ld_data_i | input | 8 | Byte to store |
| lane_a_i | input | 32 | Lane A input word |
| lane_b_i | input | 32 | Lane B input word |
| lane_a_o | output | 32 | Lane A mixed result |
| lane_b_o | output | 32 | Lane B mixed result |

## Verification
The hardest case to reach from the ports is one byte position being routed to the wrong table. With all four tables holding the same data, or with zeroed tables, that fault cannot be seen. The bench therefore fills each table with its own random bytes before it drives random words on both lanes. It also writes a single entry in one table on an otherwise empty bank, which isolates one matrix column. The dropped-write case under busy is checked by reading the targeted entry back through a lane right after the write attempt.

// File: rtl/gfun_pkg.sv
package gfun_pkg;
   localparam int GF_W = 8;

   // multiply in GF(2^8) reduced by poly (bit 8 implied)
   function automatic logic [GF_W-1:0] gf_mul(input logic [GF_W-1:0] a,
                                             input logic [GF_W-1:0] b,
                                             input logic [GF_W:0]   poly);
      logic [GF_W-1:0] acc;
      logic [GF_W-1:0] sh;
      acc = '0;
      sh  = a;
      for (int i = 0; i < GF_W; i++) begin
         if (b[i]) acc = acc ^ sh;
         if (sh[GF_W-1]) sh = {sh[GF_W-2:0], 1'b0} ^ poly[GF_W-1:0];
         else            sh = {sh[GF_W-2:0], 1'b0};
      end
      return acc;
   endfunction

   // fixed mixing matrix coefficient, row r = output byte, col c = input byte
   function automatic logic [7:0] mix_coef(input int r, input int c);
      logic [31:0] row;
      case (r)
         0:       row = {8'h5B, 8'h5B, 8'hEF, 8'h01};
         1:       row = {8'h01, 8'hEF, 8'hEF, 8'h5B};
         2:       row = {8'hEF, 8'h01, 8'h5B, 8'hEF};
         default: row = {8'h5B, 8'hEF, 8'h01, 8'hEF};
      endcase
      return row[c*8 +: 8];
   endfunction
endpackage

// File: rtl/gfun_sbox_bank.sv
module gfun_sbox_bank #(
   parameter int BYTE_W = 8,
   parameter int NTAB   = 4,
   parameter int LANES  = 2,
   localparam int DEPTH = 1 << BYTE_W,
   localparam int SEL_W = $clog2(NTAB),
   localparam int WORD_W = BYTE_W * NTAB
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic [SEL_W-1:0]              wr_sel,
   input  logic [BYTE_W-1:0]             wr_addr,
   input  logic [BYTE_W-1:0]             wr_data,
   input  logic [LANES-1:0][WORD_W-1:0]  rd_word,
   output logic [LANES-1:0][WORD_W-1:0]  rd_sub
);
   logic [BYTE_W-1:0] tbl_q [NTAB][DEPTH];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int t = 0; t < NTAB; t++)
            for (int e = 0; e < DEPTH; e++)
               tbl_q[t][e] <= '0;
      end else if (wr_en) begin
         tbl_q[wr_sel][wr_addr] <= wr_data;
      end
   end

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      for (genvar t = 0; t < NTAB; t++) begin : g_tab
         assign rd_sub[l][t*BYTE_W +: BYTE_W] = tbl_q[t][rd_word[l][t*BYTE_W +: BYTE_W]];
      end
   end
endmodule

// File: rtl/gfun_mds_mix.sv
module gfun_mds_mix
   import gfun_pkg::*;
#(
   parameter int          NBYTES = 4,
   parameter logic [8:0]  POLY   = 9'h169,
   localparam int WORD_W = 8 * NBYTES
) (
   input  logic [WORD_W-1:0] sub_i,
   output logic [WORD_W-1:0] mix_o
);
   for (genvar r = 0; r < NBYTES; r++) begin : g_row
      logic [NBYTES-1:0][7:0] term;
      for (genvar c = 0; c < NBYTES; c++) begin : g_col
         assign term[c] = gf_mul(mix_coef(r, c), sub_i[c*8 +: 8], POLY);
      end
      always_comb begin
         mix_o[r*8 +: 8] = '0;
         for (int c = 0; c < NBYTES; c++) mix_o[r*8 +: 8] = mix_o[r*8 +: 8] ^ term[c];
      end
   end
endmodule

// File: rtl/gfun_mixer.sv
module gfun_mixer #(
   parameter int         BYTE_W = 8,
   parameter int         NBYTES = 4,
   parameter int         LANES  = 2,
   parameter logic [8:0] POLY   = 9'h169,
   localparam int WORD_W = BYTE_W * NBYTES,
   localparam int SEL_W  = $clog2(NBYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              busy_i,
   input  logic              ld_we_i,
   input  logic [SEL_W-1:0]  ld_sel_i,
   input  logic [BYTE_W-1:0] ld_addr_i,
   input  logic [BYTE_W-1:0] ld_data_i,
   input  logic [WORD_W-1:0] lane_a_i,
   input  logic [WORD_W-1:0] lane_b_i,
   output logic [WORD_W-1:0] lane_a_o,
   output logic [WORD_W-1:0] lane_b_o
);
   if (BYTE_W != 8) begin : g_bad_byte
      $error("gfun_mixer: BYTE_W must be 8 for the GF(2^8) mixer");
   end
   if (NBYTES != 4) begin : g_bad_nbytes
      $error("gfun_mixer: the mixing matrix is 4x4, NBYTES must be 4");
   end
   if (LANES != 2) begin : g_bad_lanes
      $error("gfun_mixer: exactly two read lanes are brought to ports");
   end

   logic [LANES-1:0][WORD_W-1:0] word_in;
   logic [LANES-1:0][WORD_W-1:0] word_sub;
   logic [LANES-1:0][WORD_W-1:0] word_mix;
   logic                         wr_ok;

   assign wr_ok      = ld_we_i & ~busy_i;
   assign word_in[0] = lane_a_i;
   assign word_in[1] = lane_b_i;

   gfun_sbox_bank #(.BYTE_W(BYTE_W), .NTAB(NBYTES), .LANES(LANES)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_ok),
      .wr_sel  (ld_sel_i),
      .wr_addr (ld_addr_i),
      .wr_data (ld_data_i),
      .rd_word (word_in),
      .rd_sub  (word_sub)
   );

   for (genvar l = 0; l < LANES; l++) begin : g_mix
      gfun_mds_mix #(.NBYTES(NBYTES), .POLY(POLY)) u_mix (
         .sub_i (word_sub[l]),
         .mix_o (word_mix[l])
      );
   end

   assign lane_a_o = word_mix[0];
   assign lane_b_o = word_mix[1];
endmodule

// File: rtl/gfun_mixer_chk.sv
module gfun_mixer_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        busy_i,
   input logic        ld_we_i,
   input logic [31:0] lane_a_i,
   input logic [31:0] lane_b_i,
   input logic [31:0] lane_a_o,
   input logic [31:0] lane_b_o
);
   // R1
   reset_clears_chk: assert property (@(posedge clk)
      !rst_n |=> (lane_a_o == 32'h0 && lane_b_o == 32'h0));

   // R6
   lanes_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lane_a_i == lane_b_i) |-> (lane_a_o == lane_b_o));

   // R3
   busy_hold_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((!$past(ld_we_i) || $past(busy_i)) && $stable(lane_a_i)) |-> $stable(lane_a_o));

   // R8
   busy_hold_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((!$past(ld_we_i) || $past(busy_i)) && $stable(lane_b_i)) |-> $stable(lane_b_o));
endmodule

bind gfun_mixer gfun_mixer_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .busy_i   (busy_i),
   .ld_we_i  (ld_we_i),
   .lane_a_i (lane_a_i),
   .lane_b_i (lane_b_i),
   .lane_a_o (lane_a_o),
   .lane_b_o (lane_b_o)
);

// File: tb/gfun_mixer_bench.sv
module gfun_mixer_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        busy_i = 1'b0;
   logic        ld_we_i = 1'b0;
   logic [1:0]  ld_sel_i = '0;
   logic [7:0]  ld_addr_i = '0;
   logic [7:0]  ld_data_i = '0;
   logic [31:0] lane_a_i = '0;
   logic [31:0] lane_b_i = '0;
   logic [31:0] lane_a_o;
   logic [31:0] lane_b_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;
   logic [7:0] model [4][256];

   always #5 clk = ~clk;

   gfun_mixer u_gfun_mixer (.*);

   function automatic logic [7:0] ref_mul(input logic [7:0] a, input logic [7:0] b);
      logic [7:0] p = 8'h00;
      logic [7:0] x = a;
      for (int i = 0; i < 8; i++) begin
         if (b[i]) p ^= x;
         x = x[7] ? ({x[6:0], 1'b0} ^ 8'h69) : {x[6:0], 1'b0};
      end
      return p;
   endfunction

   function automatic logic [31:0] ref_g(input logic [31:0] w);
      logic [7:0] m [4][4];
      logic [7:0] y [4];
      logic [31:0] r = '0;
      m[0] = '{8'h01, 8'hEF, 8'h5B, 8'h5B};
      m[1] = '{8'h5B, 8'hEF, 8'hEF, 8'h01};
      m[2] = '{8'hEF, 8'h5B, 8'h01, 8'hEF};
      m[3] = '{8'hEF, 8'h01, 8'hEF, 8'h5B};
      for (int k = 0; k < 4; k++) y[k] = model[k][w[k*8 +: 8]];
      for (int i = 0; i < 4; i++) begin
         logic [7:0] b = 8'h00;
         for (int j = 0; j < 4; j++) b ^= ref_mul(m[i][j], y[j]);
         r[i*8 +: 8] = b;
      end
      return r;
   endfunction

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [1:0] s, input logic [7:0] a, input logic [7:0] d, input bit bz);
      @(negedge clk);
      ld_we_i = 1'b1; ld_sel_i = s; ld_addr_i = a; ld_data_i = d; busy_i = bz;
      @(negedge clk);
      ld_we_i = 1'b0; busy_i = 1'b0;
      if (!bz) model[s][a] = d;
   endtask

   task automatic drive_chk(input string req, input logic [31:0] a, input logic [31:0] b);
      lane_a_i = a; lane_b_i = b;
      #1;
      check(req, lane_a_o, ref_g(a));
      check(req, lane_b_o, ref_g(b));
   endtask

   initial begin
      void'($urandom(32'd4242));
      for (int t = 0; t < 4; t++) for (int e = 0; e < 256; e++) model[t][e] = 8'h00;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state: zero tables give zero output
      drive_chk("R1", 32'hDEADBEEF, 32'h01234567);
      check("R1", lane_a_o, 32'h0);
      // R2 R5 single entry in table 0 isolates matrix column 0
      wr(2'd0, 8'h01, 8'h01, 1'b0);
      @(negedge clk);
      lane_a_i = 32'h00000001; #1;
      check("R5", lane_a_o, 32'hEFEF5B01);
      check("R2", lane_a_o, ref_g(32'h00000001));
      // R4 table 2 only for byte 2
      wr(2'd2, 8'h7F, 8'hA5, 1'b0);
      @(negedge clk);
      drive_chk("R4", 32'h007F0000, 32'h7F7F007F);
      // R3 write under busy is dropped
      wr(2'd2, 8'h7F, 8'h3C, 1'b1);
      @(negedge clk);
      drive_chk("R3", 32'h007F0000, 32'h00000000);
      check("R3", lane_a_o, ref_g(32'h007F0000));
      // load all tables with random bytes
      for (int t = 0; t < 4; t++)
         for (int e = 0; e < 256; e++)
            wr(t[1:0], e[7:0], 8'($urandom), 1'b0);
      @(negedge clk);
      // R5 R6 random words on both lanes
      for (int n = 0; n < 200; n++) begin
         @(negedge clk);
         drive_chk("R5", $urandom, $urandom);
      end
      // R6 equal inputs
      @(negedge clk);
      drive_chk("R6", 32'hFF00AA55, 32'hFF00AA55);
      check("R6", lane_a_o, lane_b_o);
      // R7 combinational: change input mid-cycle
      @(posedge clk); #2;
      drive_chk("R7", 32'h12345678, 32'h9ABCDEF0);
      #1;
      drive_chk("R7", 32'h0F0F0F0F, 32'hF0F0F0F0);
      // R8 persistence after idle cycles and random reads
      for (int n = 0; n < 50; n++) begin
         @(negedge clk);
         lane_a_i = $urandom; lane_b_i = $urandom;
      end
      @(negedge clk);
      drive_chk("R8", 32'hFFFFFFFF, 32'h00000000);
      // R3 busy again on loaded tables
      wr(2'd1, 8'h10, ~model[1][8'h10], 1'b1);
      @(negedge clk);
      drive_chk("R3", 32'h00001000, 32'h10101010);
      // R1 reset clears loaded tables
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      for (int t = 0; t < 4; t++) for (int e = 0; e < 256; e++) model[t][e] = 8'h00;
      drive_chk("R1", 32'hCAFEF00D, 32'h55AA55AA);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule